// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block guards a system against runaway software. A free-running prescaler divides the clock into ticks. A time-out counter counts those ticks up to a limit chosen by a two-bit rate field. If software does not service the block before the limit is passed, the block raises a system-reset request for a fixed number of cycles. It then starts counting again from zero.

Servicing takes two writes to an 8-bit service port. An arm key (0x55) must come first, followed by a clear key (0xAA). Any number of other bus cycles may fall between the two writes. The watchdog enable is captured when reset is applied. In test mode, an inhibit bit starts at one and blocks reset requests until software writes it to zero. In normal mode, the rate field can be written once only, and only within an early window after reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, sys_rst_o is 0 and rate_o is 00. inhib_o equals test_mode_i, which is 1 in test mode and 0 in normal mode.
- R2: The prescaler period is P = 2^BASE_EXP cycles. Rate value r sets a limit of L = 2^(EXP_STEP*r) ticks. With the defaults, rates 00, 01, 10 and 11 give total divisors of 2^15, 2^17, 2^19 and 2^21. After reset or a clear, the time-out asserts sys_rst_o between L*P+1 and (L+1)*P cycles later. It is never early.
- R3: Each time-out holds sys_rst_o high for exactly PULSE_LEN consecutive cycles. The tick counter then restarts from zero, so the next time-out follows within L*P+1 to (L+1)*P+PULSE_LEN cycles of the previous rise.
- R4: In normal mode (test_mode_i = 0), the first rate write is accepted only if it is sampled at clock edge k ≤ WINDOW, counting edges after reset release from 1. Later writes, and any write after the first one, leave rate_o unchanged.
- R5: In test mode, the rate field accepts any number of writes at any time.
- R6: A service write of 0x55 arms the block. A later write of 0xAA, with any other writes allowed in between, clears the tick counter and so postpones the time-out.
- R7: A write of 0xAA while not armed has no effect. A clear uses up the arm, so a second 0xAA after a clear also has no effect.
- R8: cfg_enable_i is captured only while rst is high. If the captured value is 0, sys_rst_o is never asserted, whatever the input does after reset.
- R9: While inhib_o is 1, time-outs do not assert sys_rst_o. A write on inhib_we_i updates inhib_o only in test mode and is ignored in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_enable_i | input | 1 | Watchdog enable, captured during reset |
| test_mode_i | input | 1 | 1 selects test/bootstrap mode |
| svc_we_i | input | 1 | Service register write strobe |
| svc_data_i | input | 8 | Service register write data |
| rate_we_i | input | 1 | Rate field write strobe |
| rate_data_i | input | 2 | Rate field write data |
| rate_o | output | 2 | Current rate field |
| inhib_we_i | input | 1 | Inhibit bit write strobe |
| inhib_data_i | input | 1 | Inhibit bit write data |
| inhib_o | output | 1 | Current inhibit bit |
| sys_rst_o | output | 1 | System reset request |

## Verification
The bench builds the block with BASE_EXP = 3 and EXP_STEP = 2, which gives a prescaler period of 8 cycles and limits of 1, 4, 16 and 64 ticks. Even the slowest rate then times out within about 520 cycles. Every time-out window can therefore be measured to the cycle from reset release or from a clear. WINDOW stays at 64, so the bench can place rate writes exactly on the last accepted edge and on the first rejected edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] ARM_KEY = 8'h55;
  localparam logic [KEY_W-1:0] CLR_KEY = 8'hAA;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_EXP = 15
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic [BASE_EXP-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // one tick per full wrap of the free-running divider
  assign tick_o = &pre_q;
endmodule

// File: rtl/wdt_rate_reg.sv
module wdt_rate_reg #(
  parameter int RATE_W = 2,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode_i,
  input  logic              we_i,
  input  logic [RATE_W-1:0] data_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              win_open_o
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] win_q;
  logic             used_q;
  logic             accept;

  assign win_open_o = (win_q < WIN_W'(WINDOW));
  assign accept     = we_i && (test_mode_i || (win_open_o && !used_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      used_q <= 1'b0;
      rate_o <= '0;
    end else begin
      if (win_open_o) win_q <= win_q + 1'b1;
      if (accept) begin
        rate_o <= data_i;
        used_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [KEY_W-1:0] data_i,
  output logic             clear_o
);
  logic armed_q;

  assign clear_o = we_i && armed_q && (data_i == CLR_KEY);

  always_ff @(posedge clk) begin
    if (rst)                             armed_q <= 1'b0;
    else if (we_i && data_i == ARM_KEY)  armed_q <= 1'b1;
    else if (clear_o)                    armed_q <= 1'b0;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 15,
  parameter int EXP_STEP  = 2,
  parameter int RATE_W    = 2,
  parameter int WINDOW    = 64,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable_i,
  input  logic              test_mode_i,
  input  logic              svc_we_i,
  input  logic [KEY_W-1:0]  svc_data_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_data_i,
  output logic [RATE_W-1:0] rate_o,
  input  logic              inhib_we_i,
  input  logic              inhib_data_i,
  output logic              inhib_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = EXP_STEP * ((1 << RATE_W) - 1) + 1;
  localparam int PLS_W = $clog2(PULSE_LEN + 1);

  logic             tick;
  logic             clear;
  logic             win_open;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [PLS_W-1:0] pulse_q;

  wdt_prescaler #(.BASE_EXP(BASE_EXP)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  wdt_rate_reg #(.RATE_W(RATE_W), .WINDOW(WINDOW)) u_rate (
    .clk(clk), .rst(rst), .test_mode_i(test_mode_i),
    .we_i(rate_we_i), .data_i(rate_data_i),
    .rate_o(rate_o), .win_open_o(win_open)
  );

  wdt_key_seq u_key (
    .clk(clk), .rst(rst), .we_i(svc_we_i), .data_i(svc_data_i), .clear_o(clear)
  );

  assign limit = CNT_W'(1) << (EXP_STEP * int'(rate_o));

  // enable captured only during reset; inhibit defaults on in test mode
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= cfg_enable_i;
      inhib_o <= test_mode_i;
    end else if (inhib_we_i && test_mode_i) begin
      inhib_o <= inhib_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      pulse_q   <= '0;
      sys_rst_o <= 1'b0;
    end else if (pulse_q != '0) begin
      pulse_q   <= pulse_q - 1'b1;
      sys_rst_o <= (pulse_q != PLS_W'(1));
      cnt_q     <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == limit) begin
        cnt_q <= '0;
        if (en_q && !inhib_o) begin
          pulse_q   <= PLS_W'(PULSE_LEN);
          sys_rst_o <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int RATE_W    = 2,
  parameter int PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              test_mode_i,
  input logic              rate_we_i,
  input logic [RATE_W-1:0] rate_o,
  input logic              win_open,
  input logic              en_q,
  input logic              inhib_o,
  input logic              sys_rst_o
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst || !sys_rst_o) hi_q <= '0;
    else if (hi_q < HW'(PULSE_LEN + 1)) hi_q <= hi_q + 1'b1;
  end

  p_pulse_max_r3: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> hi_q < HW'(PULSE_LEN));

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> hi_q == HW'(PULSE_LEN));

  p_rate_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rate_we_i) |-> $stable(rate_o));

  p_rate_window_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rate_o) && !$past(test_mode_i)) |-> $past(win_open));

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> en_q);

  p_inhibit_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> !$past(inhib_o));
endmodule

bind keyed_watchdog wdt_checker #(.RATE_W(RATE_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .test_mode_i(test_mode_i), .rate_we_i(rate_we_i),
  .rate_o(rate_o), .win_open(win_open), .en_q(en_q), .inhib_o(inhib_o),
  .sys_rst_o(sys_rst_o)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int BE = 3, ES = 2, WIN = 64, PL = 4, P = 8;

  logic clk = 1'b0, rst = 1'b0, cfg_en = 1'b0, tmode = 1'b0;
  logic svc_we = 1'b0, rate_we = 1'b0, inh_we = 1'b0, inh_d = 1'b0;
  logic [7:0] svc_d = '0;
  logic [1:0] rate_d = '0, rate_o;
  logic inhib_o, sys_rst_o;
  int cyc = 0, checks = 0, errors = 0;

  keyed_watchdog #(.BASE_EXP(BE), .EXP_STEP(ES), .WINDOW(WIN), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst(rst), .cfg_enable_i(cfg_en), .test_mode_i(tmode),
    .svc_we_i(svc_we), .svc_data_i(svc_d), .rate_we_i(rate_we), .rate_data_i(rate_d),
    .rate_o(rate_o), .inhib_we_i(inh_we), .inhib_data_i(inh_d), .inhib_o(inhib_o),
    .sys_rst_o(sys_rst_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit tm, input bit en);
    @(negedge clk);
    rst = 1'b1; tmode = tm; cfg_en = en;
    svc_we = 0; rate_we = 0; inh_we = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic go_edge(input int k);
    @(negedge clk);
    while (cyc < k - 1) @(negedge clk);
  endtask

  task automatic svc_at(input int k, input logic [7:0] d);
    go_edge(k); svc_we = 1; svc_d = d;
    @(negedge clk); svc_we = 0;
  endtask

  task automatic rate_at(input int k, input logic [1:0] d);
    go_edge(k); rate_we = 1; rate_d = d;
    @(negedge clk); rate_we = 0;
  endtask

  task automatic inhib_at(input int k, input logic d);
    go_edge(k); inh_we = 1; inh_d = d;
    @(negedge clk); inh_we = 0;
  endtask

  task automatic find_rise(input int maxk, output int k);
    k = -1;
    forever begin
      if (sys_rst_o) begin k = cyc; break; end
      if (cyc >= maxk) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    do_reset(0, 1);
    chk(sys_rst_o == 0, "R1", "sys_rst_o after reset", sys_rst_o, 0);
    chk(rate_o == 0, "R1", "rate_o after reset", rate_o, 0);
    chk(inhib_o == 0, "R1", "inhib_o normal mode", inhib_o, 0);
  endtask

  task automatic t_rate00_pulse;
    int k, k2, w;
    do_reset(0, 1);
    find_rise(100, k);
    chk(k >= P + 1 && k <= 2 * P, "R2", "rate00 time-out cycle", k, 2 * P);
    w = 0;
    while (sys_rst_o) begin w++; @(negedge clk); end
    chk(w == PL, "R3", "pulse width", w, PL);
    find_rise(200, k2);
    chk(k2 > 0 && k2 - k >= P + 1 && k2 - k <= 2 * P + PL, "R3", "restart interval", k2 - k, 2 * P);
  endtask

  task automatic t_rate11;
    int k;
    do_reset(0, 1);
    rate_at(2, 2'b11);
    chk(rate_o == 3, "R4", "rate write in window", rate_o, 3);
    find_rise(700, k);
    chk(k >= 64 * P + 1 && k <= 65 * P, "R2", "rate11 time-out cycle", k, 65 * P);
  endtask

  task automatic t_write_once;
    int k;
    do_reset(0, 1);
    rate_at(3, 2'b10);
    rate_at(6, 2'b01);
    chk(rate_o == 2, "R4", "second rate write ignored", rate_o, 2);
    find_rise(200, k);
    chk(k >= 16 * P + 1 && k <= 17 * P, "R2", "rate10 time-out cycle", k, 17 * P);
  endtask

  task automatic t_window;
    do_reset(0, 1);
    rate_at(WIN, 2'b01);
    chk(rate_o == 1, "R4", "write on last window edge", rate_o, 1);
    do_reset(0, 1);
    rate_at(WIN + 1, 2'b01);
    chk(rate_o == 0, "R4", "write after window ignored", rate_o, 0);
  endtask

  task automatic t_test_mode;
    int k;
    do_reset(1, 1);
    chk(inhib_o == 1, "R1", "inhib_o test mode", inhib_o, 1);
    rate_at(100, 2'b01);
    rate_at(120, 2'b10);
    chk(rate_o == 2, "R5", "late repeated rate writes in test mode", rate_o, 2);
    find_rise(130, k);
    chk(k == -1, "R9", "inhibited time-outs", k, -1);
    inhib_at(131, 1'b0);
    chk(inhib_o == 0, "R9", "inhibit cleared in test mode", inhib_o, 0);
    find_rise(131 + 17 * P + 2, k);
    chk(k > 131, "R9", "reset after inhibit cleared", k, 131 + 17 * P);
  endtask

  task automatic t_inhib_normal;
    int k;
    do_reset(0, 1);
    inhib_at(3, 1'b1);
    chk(inhib_o == 0, "R9", "inhibit write ignored in normal mode", inhib_o, 0);
    find_rise(100, k);
    chk(k >= P + 1 && k <= 2 * P, "R9", "time-out not blocked", k, 2 * P);
  endtask

  task automatic t_enable;
    int k;
    do_reset(0, 0);
    cfg_en = 1'b1;
    find_rise(150, k);
    chk(k == -1, "R8", "disabled watchdog stays quiet", k, -1);
  endtask

  task automatic t_service;
    int k;
    bit seen;
    seen = 0;
    do_reset(0, 1);
    rate_at(2, 2'b01);
    for (int e = 10; e <= 186; e += 16) begin
      svc_at(e, 8'h55);
      if (sys_rst_o) seen = 1;
      svc_at(e + 3, 8'hAA);
      if (sys_rst_o) seen = 1;
    end
    chk(!seen, "R6", "regular service prevents reset", seen, 0);
    find_rise(300, k);
    chk(k >= 189 + 4 * P + 1 && k <= 189 + 5 * P, "R6", "time-out after last clear", k, 224);
  endtask

  task automatic t_noarm;
    int k;
    do_reset(0, 1);
    svc_at(12, 8'hAA);
    find_rise(100, k);
    chk(k >= P + 1 && k <= 2 * P, "R7", "clear without arm ignored", k, 2 * P);
  endtask

  task automatic t_between;
    int k;
    do_reset(0, 1);
    svc_at(3, 8'h55);
    svc_at(5, 8'h12);
    svc_at(12, 8'hAA);
    find_rise(100, k);
    chk(k >= 12 + P + 1 && k <= 12 + 2 * P, "R6", "clear after other write", k, 24);
  endtask

  task automatic t_consume;
    int k;
    do_reset(0, 1);
    svc_at(3, 8'h55);
    svc_at(5, 8'hAA);
    svc_at(14, 8'hAA);
    find_rise(100, k);
    chk(k >= P + 1 && k <= 2 * P, "R7", "second clear without arm ignored", k, 2 * P);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rate00_pulse();
    t_rate11();
    t_write_once();
    t_window();
    t_test_mode();
    t_inhib_normal();
    t_enable();
    t_service();
    t_noarm();
    t_between();
    t_consume();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule